// File: doc/BRIEF.md
# Master Tenure Latency Timer

This block sits beside a bus master port and decides when the burst it is running has to hand the bus back. When a new transaction begins, an 8-bit down-counter takes a programmable start value. It then counts down on every clock while the master holds the bus. The counter stops at zero, and zero means the tenure allowance is used up.

The block asks for the end of the tenure only when two things are true at once: the allowance is used up, and the arbiter has taken the grant away. If the grant stays asserted after expiry, the burst may go on. For a write-and-invalidate burst the request is held back further, until the address of the next data phase is aligned to a programmable cacheline size. The request tells the port to make the coming data phase its last one.

A chip uses one instance for each bus side, and each instance has its own timer. On a side where the arbiter is on chip, the grant input can be driven by an internal arbiter signal rather than by a pin.

Top module: `tenure_guard`

## Requirements
- R1: While reset is active, and after it is released, the timer value is 0.
- R2: A new-transaction strobe loads the timer from the programmed start value on the next clock edge. This happens whether or not the bus is owned, and takes priority over counting.
- R3: With no new-transaction strobe, the bus owned and a non-zero timer, the timer drops by exactly one per clock.
- R4: While the bus is not owned and no new-transaction strobe is present, the timer holds its value.
- R5: Once the timer reaches 0 it stays at 0 until the next new-transaction strobe.
- R6: The expired output is 1 exactly when the timer value is 0.
- R7: The end-tenure output is 1 exactly when all of these hold: the bus is owned, the timer is expired, the grant input is 0, and either the write-and-invalidate input is 0 or the next address is on a cacheline boundary.
- R8: While the grant input is 1, the end-tenure output stays 0, even with the timer expired.
- R9: The cacheline size is 2^lineLog2 dwords. With write-and-invalidate set, the end-tenure output is held at 0 until bits [lineLog2-1:0] of the dword next address are all zero.
- R10: With lineLog2 equal to 0, every next address counts as a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latencyInit | input | 8 | Programmed tenure allowance in clocks |
| lineLog2 | input | 3 | log2 of the cacheline size in dwords |
| frameStart | input | 1 | One-cycle strobe when a new transaction starts |
| busOwned | input | 1 | Master currently owns the bus |
| grantActive | input | 1 | Grant, active high (pin or internal arbiter) |
| isWriteInval | input | 1 | Current burst is write-and-invalidate |
| nextAddr | input | 30 | Dword address of the next data phase |
| timerNow | output | 8 | Current timer value |
| timerExpired | output | 1 | Timer is at zero |
| endTenure | output | 1 | Make the next data phase the final one |

## Verification
The assertions check the timer's movement on every cycle: load, one-step decrement, holding and saturation. They also check that end-tenure never appears with the grant present, with the timer still running, or off a cacheline boundary during a write-and-invalidate burst. What the assertions cannot show is that end-tenure really rises at the first cycle where all of its conditions meet. That is left to the bench's scenarios: the grant held past expiry and then dropped, the boundary reached under several line sizes, and the single-dword line.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dec;
  } ctrlStrobes_t;
endpackage

// File: rtl/tenure_datapath.sv
module tenure_datapath
  import tenure_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 30,
  parameter int LOG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [LOG_W-1:0] lineLog2,
  input  logic [AW-1:0]    nextAddr,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             aligned
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] lineMask;

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (strobes.load)  count <= loadVal;
    else if (strobes.dec)   count <= count - CNT_W'(1);
  end

  assign expired = (count == '0);

  always_comb begin
    lineMask = (ONE << lineLog2) - ONE;
    aligned  = ((nextAddr & lineMask) == '0);
  end
endmodule

// File: rtl/tenure_control.sv
module tenure_control
  import tenure_pkg::*;
(
  input  logic         frameStart,
  input  logic         busOwned,
  input  logic         grantActive,
  input  logic         isWriteInval,
  input  logic         expired,
  input  logic         aligned,
  output ctrlStrobes_t strobes,
  output logic         endTenure
);
  logic preempt;

  always_comb begin
    strobes.load = frameStart;
    strobes.dec  = !frameStart && busOwned && !expired;
    preempt      = busOwned && expired && !grantActive;
    endTenure    = preempt && (!isWriteInval || aligned);
  end
endmodule

// File: rtl/tenure_guard.sv
module tenure_guard
  import tenure_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 30,
  parameter int LOG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] latencyInit,
  input  logic [LOG_W-1:0] lineLog2,
  input  logic             frameStart,
  input  logic             busOwned,
  input  logic             grantActive,
  input  logic             isWriteInval,
  input  logic [AW-1:0]    nextAddr,
  output logic [CNT_W-1:0] timerNow,
  output logic             timerExpired,
  output logic             endTenure
);
  ctrlStrobes_t strobes;
  logic         alignedHit;

  tenure_datapath #(.CNT_W(CNT_W), .AW(AW), .LOG_W(LOG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(latencyInit),
    .lineLog2(lineLog2), .nextAddr(nextAddr), .count(timerNow),
    .expired(timerExpired), .aligned(alignedHit)
  );

  tenure_control u_ctl (
    .frameStart(frameStart), .busOwned(busOwned), .grantActive(grantActive),
    .isWriteInval(isWriteInval), .expired(timerExpired), .aligned(alignedHit),
    .strobes(strobes), .endTenure(endTenure)
  );
endmodule

// File: rtl/tenure_guard_chk.sv
module tenure_guard_chk #(
  parameter int CNT_W = 8,
  parameter int AW    = 30,
  parameter int LOG_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] latencyInit,
  input logic [LOG_W-1:0] lineLog2,
  input logic             frameStart,
  input logic             busOwned,
  input logic             grantActive,
  input logic             isWriteInval,
  input logic [AW-1:0]    nextAddr,
  input logic [CNT_W-1:0] timerNow,
  input logic             timerExpired,
  input logic             endTenure
);
  logic [AW-1:0] lowBits;
  always_comb lowBits = nextAddr & ((AW'(1) << lineLog2) - AW'(1));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> timerNow == $past(latencyInit));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && busOwned && timerNow != '0) |=> timerNow == $past(timerNow) - CNT_W'(1));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !busOwned) |=> $stable(timerNow));
  // R5
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && timerNow == '0) |=> timerNow == '0);
  // R7
  end_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    endTenure |-> (timerExpired && busOwned));
  // R8
  grant_blocks_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantActive |-> !endTenure);
  // R9
  line_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endTenure && isWriteInval) |-> lowBits == '0);
endmodule

bind tenure_guard tenure_guard_chk #(.CNT_W(CNT_W), .AW(AW), .LOG_W(LOG_W)) u_chk (
  .clk(clk), .rstN(rstN), .latencyInit(latencyInit), .lineLog2(lineLog2),
  .frameStart(frameStart), .busOwned(busOwned), .grantActive(grantActive),
  .isWriteInval(isWriteInval), .nextAddr(nextAddr), .timerNow(timerNow),
  .timerExpired(timerExpired), .endTenure(endTenure)
);

// File: tb/sim_tenure_guard.sv
module sim_tenure_guard;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  latencyInit;
  logic [2:0]  lineLog2;
  logic        frameStart, busOwned, grantActive, isWriteInval;
  logic [29:0] nextAddr;
  logic [7:0]  timerNow;
  logic        timerExpired, endTenure;

  int tests = 0;
  int fails = 0;
  int mCount = 0;
  string tTag = "R1";

  always #2 clk = ~clk;

  tenure_guard u0 (
    .clk(clk), .rstN(rstN), .latencyInit(latencyInit), .lineLog2(lineLog2),
    .frameStart(frameStart), .busOwned(busOwned), .grantActive(grantActive),
    .isWriteInval(isWriteInval), .nextAddr(nextAddr), .timerNow(timerNow),
    .timerExpired(timerExpired), .endTenure(endTenure)
  );

  function automatic bit onBoundary(logic [29:0] a, logic [2:0] lg);
    for (int i = 0; i < 8; i++)
      if (i < lg && a[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit wantEnd(int cnt, bit own, bit gnt, bit wi, logic [29:0] a, logic [2:0] lg);
    return own && cnt == 0 && !gnt && (!wi || onBoundary(a, lg));
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit fs, bit own, bit gnt, bit wi, logic [29:0] a, logic [2:0] lg, logic [7:0] li);
    string eTag;
    @(negedge clk);
    frameStart = fs; busOwned = own; grantActive = gnt; isWriteInval = wi;
    nextAddr = a; lineLog2 = lg; latencyInit = li;
    #1;
    chk(tTag, int'(timerNow), mCount);
    chk("R6", int'(timerExpired), int'(mCount == 0));
    if (gnt) eTag = "R8";
    else if (wi && lg == 0) eTag = "R10";
    else if (wi) eTag = "R9";
    else eTag = "R7";
    chk(eTag, int'(endTenure), int'(wantEnd(mCount, own, gnt, wi, a, lg)));
    @(posedge clk);
    if (fs) begin mCount = int'(li); tTag = "R2"; end
    else if (own && mCount != 0) begin mCount--; tTag = "R3"; end
    else if (mCount == 0) tTag = "R5";
    else tTag = "R4";
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; frameStart = 0; busOwned = 0; grantActive = 0; isWriteInval = 0;
    nextAddr = '0; lineLog2 = '0; latencyInit = 8'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(timerNow), 0);
    rstN = 1'b1;
    #1 chk("R1", int'(timerNow), 0);

    // grant held past expiry, then dropped (R8, R7)
    step(1, 1, 1, 0, 30'd1, 3'd2, 8'd3);
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 30'd1, 3'd2, 8'd3);
    step(0, 1, 0, 0, 30'd1, 3'd2, 8'd3);
    // idle hold (R4)
    step(1, 0, 1, 0, 30'd0, 3'd0, 8'd5);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 30'd0, 3'd0, 8'd5);
    // write-and-invalidate walking to a boundary, 8-dword line (R9)
    step(1, 1, 0, 1, 30'd1, 3'd3, 8'd2);
    for (int i = 2; i < 10; i++) step(0, 1, 0, 1, 30'(i), 3'd3, 8'd2);
    // single-dword line: every address is a boundary (R10)
    step(0, 1, 0, 1, 30'd7, 3'd0, 8'd2);
    step(0, 1, 0, 1, 30'd13, 3'd0, 8'd2);
    // largest line, 128 dwords
    step(0, 1, 0, 1, 30'd64, 3'd7, 8'd2);
    step(0, 1, 0, 1, 30'd128, 3'd7, 8'd2);

    for (int i = 0; i < 4000; i++)
      step(($urandom % 12) == 0, ($urandom % 4) != 0, ($urandom % 2) == 1,
           ($urandom % 2) == 1, 30'($urandom), 3'($urandom), 8'($urandom % 12));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule